// File: doc/BRIEF.md
# Two-Region Block Erase Sequencer

This block turns a single erase request, given as a byte start address and a byte length, into a series of per-block erase commands. The target storage has two erase regions. The lower one holds small parameter blocks. The upper one, which begins right where the lower one ends, holds large main blocks. The sequencer first checks the request against the device size and against the block grid of the region in which each end of the range falls. It then walks the range one block at a time.

Each block is handed to a downstream erase port through a request/acknowledge handshake. After every successful block the address advances by the size of the block just erased. A request that starts in the parameter region and ends in the main region therefore changes stride partway through. The first block reported as failed ends the walk at once and returns the failing block address.

The host side is a request strobe, accepted only when the block is idle. Completion is reported as a one-cycle done pulse together with a 2-bit status.

Top module: `erase_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `ers_req` are all low.
- R2: If start plus length is greater than the device size (4 MiB with default parameters), the request ends with status 2'b01 (invalid argument) and no erase is issued.
- R3: A zero-length request that passes the size check ends with status 2'b00 (success) and no erase is issued.
- R4: The start address must be a multiple of the block size of its region: 16 KiB below 128 KiB, 128 KiB at or above it. Otherwise the status is 2'b01 and no erase is issued.
- R5: The end address (start plus length) must be a multiple of the block size of the region that contains it. An end exactly at 128 KiB counts as lying in the main region. Otherwise the status is 2'b01 and no erase is issued.
- R6: Erases are issued in ascending order, starting at the start address. The stride is 16 KiB while the address is below 128 KiB and 128 KiB from there on. The walk covers exactly the requested range.
- R7: `ers_req` stays high with a stable `ers_addr` until a cycle in which `ers_ack` is high. Each acknowledge completes exactly one block.
- R8: An acknowledge with `ers_fail` high ends the walk. The status becomes 2'b10 (erase failure), `fail_addr` holds that block's address, and no further erase is issued.
- R9: After the acknowledge of the last block without failure, the status is 2'b00. A failure on the last block still reports 2'b10.
- R10: `req_valid` is sampled only while idle. A strobe while busy does not change the block sequence or the result.
- R11: `done` is a one-cycle pulse, after which `busy` is low. `fail_addr` is zero unless the status is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request strobe, taken when idle |
| req_start | input | 32 | Byte start address of the range |
| req_len | input | 32 | Byte length of the range |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 success, 01 invalid argument, 10 erase failure |
| fail_addr | output | 32 | Address of the failing block, else zero |
| ers_req | output | 1 | Per-block erase command valid |
| ers_addr | output | 32 | Address of the block to erase |
| ers_ack | input | 1 | Block erase finished |
| ers_fail | input | 1 | Qualifies `ers_ack`: the block erase failed |

## Verification
The acknowledge of the final block is the cycle where completion, a failure report and, for a range ending just past the boundary, the stride change can all arrive together. The bench provokes this with directed requests that straddle the 128 KiB boundary and inject a failure on exactly the last block, where the failure must win over completion. Random ranges built on the block grid, with random acknowledge delays and failure positions, are judged against a bench model. That model recomputes the expected block list, status and failing address from the region rules alone. A request strobe injected mid-walk checks that accept and walk never mix.

// File: rtl/ewk_pkg.sv
package ewk_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_BADARG = 2'b01,
    ST_IOERR  = 2'b10
  } ewk_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_ERASE,
    S_DONE
  } ewk_state_e;

endpackage

// File: rtl/ewk_region_sel.sv
// Maps an address onto the block size of the erase region that holds it.
module ewk_region_sel #(
  parameter int unsigned W     = 32,
  parameter int unsigned P_BLK = 16384,
  parameter int unsigned P_CNT = 8,
  parameter int unsigned M_BLK = 131072
) (
  input  logic [W-1:0] addr,
  output logic [W-1:0] blk_bytes
);

  localparam logic [W-1:0] BOUND = W'(P_BLK * P_CNT);
  localparam logic [W-1:0] P_SZ  = W'(P_BLK);
  localparam logic [W-1:0] M_SZ  = W'(M_BLK);

  always_comb begin
    if (addr < BOUND) blk_bytes = P_SZ;
    else              blk_bytes = M_SZ;
  end

endmodule

// File: rtl/ewk_req_check.sv
// Range and block-grid validation of a latched request.
module ewk_req_check
  import ewk_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned P_BLK = 16384,
  parameter int unsigned P_CNT = 8,
  parameter int unsigned M_BLK = 131072,
  parameter int unsigned M_CNT = 31
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] len,
  output ewk_status_e   verdict,
  output logic          empty
);

  localparam int unsigned  EW  = AW + 1;
  localparam logic [EW-1:0] DEV = EW'(P_BLK * P_CNT + M_BLK * M_CNT);

  logic [EW-1:0] s_x, e_x, s_blk, e_blk;
  logic          over, s_ok, e_ok;

  ewk_region_sel #(.W(EW), .P_BLK(P_BLK), .P_CNT(P_CNT), .M_BLK(M_BLK)) u_sel_start (
    .addr      (s_x),
    .blk_bytes (s_blk)
  );

  ewk_region_sel #(.W(EW), .P_BLK(P_BLK), .P_CNT(P_CNT), .M_BLK(M_BLK)) u_sel_end (
    .addr      (e_x),
    .blk_bytes (e_blk)
  );

  always_comb begin
    s_x   = {1'b0, start};
    e_x   = s_x + {1'b0, len};
    over  = (e_x > DEV);
    empty = (len == '0);
    s_ok  = ((s_x & (s_blk - EW'(1))) == '0);
    e_ok  = ((e_x & (e_blk - EW'(1))) == '0);
    if (over)              verdict = ST_BADARG;
    else if (empty)        verdict = ST_OK;
    else if (s_ok && e_ok) verdict = ST_OK;
    else                   verdict = ST_BADARG;
  end

endmodule

// File: rtl/ewk_seq.sv
// Request acceptance, block walk and result registers.
module ewk_seq
  import ewk_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned P_BLK = 16384,
  parameter int unsigned P_CNT = 8,
  parameter int unsigned M_BLK = 131072,
  parameter int unsigned M_CNT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_len,
  input  ewk_status_e   chk_verdict,
  input  logic          chk_empty,
  output logic [AW-1:0] lat_start,
  output logic [AW-1:0] lat_len,
  output logic          busy,
  output logic          done,
  output ewk_status_e   done_status,
  output logic [AW-1:0] fail_addr,
  output logic          ers_req,
  output logic [AW-1:0] ers_addr,
  input  logic          ers_ack,
  input  logic          ers_fail
);

  localparam logic [AW-1:0] DEV = AW'(P_BLK * P_CNT + M_BLK * M_CNT);

  ewk_state_e    st_q, st_d;
  ewk_status_e   sts_q, sts_d;
  logic [AW-1:0] cur_q, cur_d, rem_q, rem_d, fa_q, fa_d;
  logic [AW-1:0] step_blk;
  logic          accept, ack_ok, fail_hit, last_blk;
  logic          walk_en, sts_en, fa_en;

  ewk_region_sel #(.W(AW), .P_BLK(P_BLK), .P_CNT(P_CNT), .M_BLK(M_BLK)) u_sel_step (
    .addr      (cur_q),
    .blk_bytes (step_blk)
  );

  // next-state logic
  always_comb begin
    accept   = (st_q == S_IDLE) && req_valid;
    ack_ok   = (st_q == S_ERASE) && ers_ack && !ers_fail;
    fail_hit = (st_q == S_ERASE) && ers_ack && ers_fail;
    last_blk = (rem_q <= step_blk);

    walk_en = accept || ack_ok;
    cur_d   = accept ? req_start : cur_q + step_blk;
    rem_d   = accept ? req_len   : rem_q - step_blk;

    fa_en = accept || fail_hit;
    fa_d  = accept ? '0 : cur_q;

    sts_en = (st_q == S_CHECK) || fail_hit || (ack_ok && last_blk);
    if (fail_hit)               sts_d = ST_IOERR;
    else if (st_q == S_CHECK)   sts_d = chk_verdict;
    else                        sts_d = ST_OK;

    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (accept) st_d = S_CHECK;
      S_CHECK: begin
        if (chk_verdict != ST_OK) st_d = S_DONE;
        else if (chk_empty)       st_d = S_DONE;
        else                      st_d = S_ERASE;
      end
      S_ERASE: if (fail_hit || (ack_ok && last_blk)) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sts_q <= ST_OK;
      cur_q <= '0;
      rem_q <= '0;
      fa_q  <= '0;
    end else begin
      st_q <= st_d;
      if (walk_en) begin
        cur_q <= cur_d;
        rem_q <= rem_d;
      end
      if (sts_en) sts_q <= sts_d;
      if (fa_en)  fa_q  <= fa_d;
    end
  end

  always_comb begin
    lat_start   = cur_q;
    lat_len     = rem_q;
    busy        = (st_q != S_IDLE);
    done        = (st_q == S_DONE);
    done_status = sts_q;
    fail_addr   = fa_q;
    ers_req     = (st_q == S_ERASE);
    ers_addr    = cur_q;
  end

  AST_ERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ers_req && !ers_ack |=> ers_req && $stable(ers_addr)); // R7

  AST_BLK_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    ers_req |-> ((ers_addr & (step_blk - AW'(1))) == '0)); // R6

  AST_ERS_IN_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ers_req |-> (ers_addr < DEV)); // R2

  AST_FAIL_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_status == ST_IOERR) |-> $past(ers_ack && ers_fail) && (fail_addr == $past(ers_addr))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R10

endmodule

// File: rtl/erase_walker.sv
module erase_walker
  import ewk_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned P_BLK = 16384,
  parameter int unsigned P_CNT = 8,
  parameter int unsigned M_BLK = 131072,
  parameter int unsigned M_CNT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_len,
  output logic          busy,
  output logic          done,
  output logic [1:0]    done_status,
  output logic [AW-1:0] fail_addr,
  output logic          ers_req,
  output logic [AW-1:0] ers_addr,
  input  logic          ers_ack,
  input  logic          ers_fail
);

  ewk_status_e   verdict, sts;
  logic          empty;
  logic [AW-1:0] lat_start, lat_len;

  ewk_req_check #(
    .AW(AW), .P_BLK(P_BLK), .P_CNT(P_CNT), .M_BLK(M_BLK), .M_CNT(M_CNT)
  ) u_check (
    .start   (lat_start),
    .len     (lat_len),
    .verdict (verdict),
    .empty   (empty)
  );

  ewk_seq #(
    .AW(AW), .P_BLK(P_BLK), .P_CNT(P_CNT), .M_BLK(M_BLK), .M_CNT(M_CNT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_start   (req_start),
    .req_len     (req_len),
    .chk_verdict (verdict),
    .chk_empty   (empty),
    .lat_start   (lat_start),
    .lat_len     (lat_len),
    .busy        (busy),
    .done        (done),
    .done_status (sts),
    .fail_addr   (fail_addr),
    .ers_req     (ers_req),
    .ers_addr    (ers_addr),
    .ers_ack     (ers_ack),
    .ers_fail    (ers_fail)
  );

  assign done_status = sts;

  AST_NO_ERS_ON_BADARG: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_status == 2'b01) |-> !$past(ers_req)); // R4

  AST_FAIL_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && (done_status != 2'b10) |-> (fail_addr == '0)); // R11

endmodule

// File: tb/erase_walker_tb.sv
module erase_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam longint P_SZ  = 16384;
  localparam longint M_SZ  = 131072;
  localparam longint BOUND = 131072;
  localparam longint DEV   = 4194304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_start, req_len;
  logic        busy, done;
  logic [1:0]  done_status;
  logic [31:0] fail_addr;
  logic        ers_req;
  logic [31:0] ers_addr;
  logic        ers_ack, ers_fail;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_walker u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_start   (req_start),
    .req_len     (req_len),
    .busy        (busy),
    .done        (done),
    .done_status (done_status),
    .fail_addr   (fail_addr),
    .ers_req     (ers_req),
    .ers_addr    (ers_addr),
    .ers_ack     (ers_ack),
    .ers_fail    (ers_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint blk_of(input longint a);
    return (a < BOUND) ? P_SZ : M_SZ;
  endfunction

  function automatic longint blk_addr(input int b);
    return (b < 8) ? b * P_SZ : BOUND + (b - 8) * M_SZ;
  endfunction

  // R2, R3, R4, R5 model
  function automatic int model_status(input longint s, input longint l);
    longint e = s + l;
    if (e > DEV) return 1;
    if (l == 0) return 0;
    if ((s % blk_of(s)) != 0) return 1;
    if ((e % blk_of(e)) != 0) return 1;
    return 0;
  endfunction

  task automatic run_req(input logic [31:0] s, input logic [31:0] l,
                         input int fail_idx, input bit poke, input string tag);
    longint exp_blk[64];
    logic [31:0] seen[64];
    int exp_n = 0, n_expect, n_seen = 0, wait_cnt, loops = 0, bad = -1;
    int exp_sts, act_sts = -1;
    longint exp_fa = 0, a, act_fa = 0;
    bit got = 0, poked = 0;

    exp_sts = model_status(s, l);
    if (exp_sts == 0) begin
      a = s;
      while (a < longint'(s) + longint'(l) && exp_n < 64) begin
        exp_blk[exp_n] = a;
        exp_n++;
        a += blk_of(a);
      end
    end
    n_expect = exp_n;
    if (exp_sts == 0 && fail_idx < exp_n) begin
      exp_sts  = 2;
      n_expect = fail_idx + 1;
      exp_fa   = exp_blk[fail_idx];
    end

    @(negedge clk);
    req_valid = 1'b1; req_start = s; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    wait_cnt = $urandom % 4;
    while (!got && loops < 3000) begin
      if (done) begin
        got = 1;
        act_sts = done_status;
        act_fa  = fail_addr;
      end else if (ers_req) begin
        if (poke && !poked) begin
          req_valid = 1'b1; req_start = 32'h0; req_len = 32'h40000;
          poked = 1;
        end
        if (wait_cnt == 0) begin
          ers_ack  = 1'b1;
          ers_fail = (n_seen == fail_idx);
          if (n_seen < 64) seen[n_seen] = ers_addr;
          n_seen++;
          wait_cnt = $urandom % 4;
        end else begin
          wait_cnt--;
        end
      end
      if (!got) begin
        @(negedge clk);
        ers_ack = 1'b0; ers_fail = 1'b0; req_valid = 1'b0;
        loops++;
      end
    end

    chk(got, tag, "done seen", got, 1);
    chk(act_sts == exp_sts, tag, "status", act_sts, exp_sts);
    chk(n_seen == n_expect, {tag, " R6/R8"}, "erase count", n_seen, n_expect);
    for (int i = 0; i < n_expect && i < n_seen && i < 64; i++)
      if (bad < 0 && longint'(seen[i]) != exp_blk[i]) bad = i;
    chk(bad < 0, {tag, " R6/R7"}, "block address",
        (bad < 0) ? 0 : longint'(seen[bad]), (bad < 0) ? 0 : exp_blk[bad]);
    chk(act_fa == exp_fa, {tag, " R8/R11"}, "fail_addr", act_fa, exp_fa);
    @(negedge clk);
    chk(!done && !busy, "R11", "done pulse width", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_start = '0; req_len = '0;
    ers_ack = 1'b0; ers_fail = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, ers_req} == 3'b000, "R1", "outputs in reset", {busy, done, ers_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, ers_req} == 3'b000, "R1", "outputs after reset", {busy, done, ers_req}, 0);

    run_req(32'h0,        32'h400000, 99, 0, "R6 full device");
    run_req(32'h1C000,    32'h24000,  99, 1, "R6 R10 boundary crossing");
    run_req(32'h8000,     32'h0,      99, 0, "R3 empty");
    run_req(32'h400000,   32'h0,      99, 0, "R3 empty at top");
    run_req(32'h3E0000,   32'h40000,  99, 0, "R2 beyond device");
    run_req(32'h30000,    32'h20000,  99, 0, "R4 start off main grid");
    run_req(32'h2000,     32'h4000,   99, 0, "R4 start off param grid");
    run_req(32'h0,        32'h24000,  99, 0, "R5 end off main grid");
    run_req(32'h0,        32'h20000,  99, 0, "R5 end at boundary");
    run_req(32'h1C000,    32'h24000,   1, 0, "R8 R9 fail on last");
    run_req(32'h0,        32'h8000,    0, 1, "R8 fail on first");
    run_req(32'h3E0000,   32'h20000,  99, 0, "R9 last main block");

    for (int it = 0; it < 40; it++) begin
      int b0 = $urandom % 39;
      int cnt = 1 + ($urandom % 6);
      int b1 = (b0 + cnt > 39) ? 39 : b0 + cnt;
      int mut = $urandom % 8;
      int fidx = (($urandom % 4) == 0) ? ($urandom % cnt) : 99;
      longint s = blk_addr(b0);
      longint l = blk_addr(b1) - s;
      if (mut == 0) s += 32'h1000;
      if (mut == 1) l += 32'h2000;
      if (mut == 2) l = DEV;
      run_req(32'(s), 32'(l), fidx, ($urandom % 3) == 0, "R2/R4/R5/R9/R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 180000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule